// File: doc/BRIEF.md
# Incremental Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a position count held in a counter register. The phase, index and strobe inputs arrive already synchronised to the system clock. Static configuration inputs choose one of four counting modes, exchange the two phase channels, and invert each of the four inputs. Index and strobe are only polarity-corrected and handed on to neighbouring logic.

A small write port loads the position counter directly, sets the value used for software initialisation, and sets the upper limit of the counting range. The counter wraps inside the range from zero to that limit. A global enable freezes the count while it is low. Every count takes effect on the clock edge that first sees the new input state, so the position output trails the inputs by one cycle.

Top module: `qdec_pos`

## Requirements
- R1: After reset the position and initial value read zero, the limit reads all ones, and `phase_err` is low.
- R2: In mode 0, the conditioned pair {A,B} is decoded at 4x. A step along 00→01→11→10→00 adds one, and a step the opposite way subtracts one. The new position appears on the clock edge that samples the new input pair. The first edge after reset only primes the decoder and does not count.
- R3: In mode 0, a jump between opposite states (both bits changing at once) leaves the position unchanged and raises `phase_err` for exactly one cycle, starting at that same edge.
- R4: In mode 1, every edge of conditioned A counts, both rising and falling. The count goes up when conditioned B is 1 and down when it is 0.
- R5: In mode 2 only rising edges of conditioned A add one, and in mode 3 only rising edges of conditioned A subtract one. Falling edges and B have no effect in these modes.
- R6: With `swap` high, the inverted A pin drives the B decode path and the inverted B pin drives the A decode path.
- R7: `inv_a`, `inv_b`, `inv_idx` and `inv_strb` invert their pins before any decoding. `idx_out` and `strb_out` are the inverted or non-inverted index and strobe pins.
- R8: Adding one to a position equal to the limit gives zero. Subtracting one from zero gives the limit.
- R9: While `enable` is low the position holds, and `phase_err` stays low.
- R10: `wr_pos` loads `wr_data` into the position. Otherwise `sw_init` loads the stored initial value. Either one overrides counting in that cycle. `wr_init` and `wr_max` store `wr_data` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global count enable |
| mode | input | 2 | 0 quadrature, 1 direction, 2 up, 3 down |
| swap | input | 1 | Exchange A and B after inversion |
| inv_a | input | 1 | Invert A pin |
| inv_b | input | 1 | Invert B pin |
| inv_idx | input | 1 | Invert index pin |
| inv_strb | input | 1 | Invert strobe pin |
| a_in | input | 1 | Phase A pin |
| b_in | input | 1 | Phase B pin |
| idx_in | input | 1 | Index pin |
| strb_in | input | 1 | Strobe pin |
| sw_init | input | 1 | Load position from initial value |
| wr_pos | input | 1 | Write `wr_data` to position |
| wr_init | input | 1 | Write `wr_data` to initial value |
| wr_max | input | 1 | Write `wr_data` to limit |
| wr_data | input | W | Write data |
| pos | output | W | Position counter |
| init_val | output | W | Initial value register |
| max_val | output | W | Limit register |
| idx_out | output | 1 | Conditioned index |
| strb_out | output | 1 | Conditioned strobe |
| phase_err | output | 1 | One-cycle illegal-transition pulse |

## Verification
If the stored previous phase state is wrong, the next input change makes the position move the wrong way, or not at all. It can also raise `phase_err` when no illegal jump happened. All of these show one cycle after the input change. A wrong wrap comparison shows only when the count crosses zero or the limit, so the bench uses a small limit to make that happen every few steps. A broken enable or priority shows as a count drift on the very next edge.

// File: rtl/qdec_pos.sv
module qdec_pos #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [1:0]   mode,
  input  logic         swap,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         inv_idx,
  input  logic         inv_strb,
  input  logic         a_in,
  input  logic         b_in,
  input  logic         idx_in,
  input  logic         strb_in,
  input  logic         sw_init,
  input  logic         wr_pos,
  input  logic         wr_init,
  input  logic         wr_max,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pos,
  output logic [W-1:0] init_val,
  output logic [W-1:0] max_val,
  output logic         idx_out,
  output logic         strb_out,
  output logic         phase_err
);

  logic a_p, b_p, ca, cb;
  logic pa, pb, primed;
  logic [1:0] cur_g, prv_g, dg;
  logic inc, dec, err;
  logic [W-1:0] nxt_up, nxt_dn;

  assign a_p      = a_in ^ inv_a;
  assign b_p      = b_in ^ inv_b;
  assign ca       = swap ? b_p : a_p;
  assign cb       = swap ? a_p : b_p;
  assign idx_out  = idx_in ^ inv_idx;
  assign strb_out = strb_in ^ inv_strb;

  assign cur_g = {ca, ca ^ cb};
  assign prv_g = {pa, pa ^ pb};
  assign dg    = cur_g - prv_g;

  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    err = 1'b0;
    if (primed && enable) begin
      unique case (mode)
        2'd0: begin
          inc = (dg == 2'd1);
          dec = (dg == 2'd3);
          err = (dg == 2'd2);
        end
        2'd1: begin
          inc = (ca != pa) && cb;
          dec = (ca != pa) && !cb;
        end
        2'd2: inc = ca && !pa;
        default: dec = ca && !pa;
      endcase
    end
  end

  assign nxt_up = (pos == max_val) ? '0 : pos + 1'b1;
  assign nxt_dn = (pos == '0) ? max_val : pos - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      init_val  <= '0;
      max_val   <= '1;
      pa        <= 1'b0;
      pb        <= 1'b0;
      primed    <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      pa        <= ca;
      pb        <= cb;
      primed    <= 1'b1;
      phase_err <= err;
      if (wr_init) init_val <= wr_data;
      if (wr_max)  max_val  <= wr_data;
      if (wr_pos)       pos <= wr_data;
      else if (sw_init) pos <= init_val;
      else if (inc)     pos <= nxt_up;
      else if (dec)     pos <= nxt_dn;
    end
  end

endmodule

module qdec_pos_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic [1:0]   mode,
  input logic         sw_init,
  input logic         wr_pos,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] pos,
  input logic [W-1:0] init_val,
  input logic [W-1:0] max_val,
  input logic         phase_err
);

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_pos && !sw_init) |=> $stable(pos));

  // R9
  no_err_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |-> ($past(enable) && $past(mode) == 2'd0));

  // R10
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pos |=> (pos == $past(wr_data)));

  // R10
  soft_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_init && !wr_pos) |=> (pos == $past(init_val)));

  // R5
  up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_pos && !sw_init) |=>
      ($stable(pos) || pos == (($past(pos) == $past(max_val)) ? '0 : $past(pos) + 1'b1)));

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !$past(wr_pos) && !$past(sw_init)) |-> $stable(pos));

endmodule

bind qdec_pos qdec_pos_chk #(.W(W)) u_chk (.*);

// File: tb/sim_qdec_pos.sv
`timescale 1ns/1ps
module sim_qdec_pos;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, swap = 1'b0;
  logic [1:0] mode = 2'd0;
  logic inv_a = 1'b0, inv_b = 1'b0, inv_idx = 1'b0, inv_strb = 1'b0;
  logic a_in = 1'b0, b_in = 1'b0, idx_in = 1'b0, strb_in = 1'b0;
  logic sw_init = 1'b0, wr_pos = 1'b0, wr_init = 1'b0, wr_max = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pos, init_val, max_val;
  logic idx_out, strb_out, phase_err;

  int n_vec = 0, n_bad = 0;
  logic [W-1:0] m_pos, m_init, m_max;
  logic m_pa, m_pb, m_primed, m_err;
  int g = 0;

  always #10 clk = ~clk;

  qdec_pos #(.W(W)) u0 (.*);

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int step_dir(input logic pa, input logic pb, input logic ca, input logic cb);
    int p, c;
    p = pa ? (pb ? 2 : 3) : (pb ? 1 : 0);
    c = ca ? (cb ? 2 : 3) : (cb ? 1 : 0);
    return (c - p + 4) % 4;
  endfunction

  task automatic model_edge();
    logic a, b, ca, cb;
    int up, dn, er, s;
    a = a_in ^ inv_a; b = b_in ^ inv_b;
    ca = swap ? b : a; cb = swap ? a : b;
    up = 0; dn = 0; er = 0;
    if (m_primed && enable) begin
      case (mode)
        2'd0: begin s = step_dir(m_pa, m_pb, ca, cb); up = (s == 1); dn = (s == 3); er = (s == 2); end
        2'd1: if (ca != m_pa) begin if (cb) up = 1; else dn = 1; end
        2'd2: up = (ca && !m_pa);
        default: dn = (ca && !m_pa);
      endcase
    end
    m_err = (er != 0);
    if (wr_pos) m_pos = wr_data;
    else if (sw_init) m_pos = m_init;
    else if (up != 0) m_pos = (m_pos == m_max) ? '0 : m_pos + 1;
    else if (dn != 0) m_pos = (m_pos == 0) ? m_max : m_pos - 1;
    if (wr_init) m_init = wr_data;
    if (wr_max) m_max = wr_data;
    m_pa = ca; m_pb = cb; m_primed = 1'b1;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, pos, m_pos);
    check(tag, {31'd0, phase_err}, {31'd0, m_err});
    check("R7", {31'd0, idx_out}, {31'd0, idx_in ^ inv_idx});
    check("R7", {31'd0, strb_out}, {31'd0, strb_in ^ inv_strb});
    check("R10", max_val, m_max);
    sw_init = 0; wr_pos = 0; wr_init = 0; wr_max = 0;
  endtask

  task automatic gstep(input int d);
    g = (g + d) % 4;
    case (g)
      0: begin a_in = 0; b_in = 0; end
      1: begin a_in = 0; b_in = 1; end
      2: begin a_in = 1; b_in = 1; end
      default: begin a_in = 1; b_in = 0; end
    endcase
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pos = '0; m_init = '0; m_max = '1; m_pa = 0; m_pb = 0; m_primed = 0; m_err = 0;
    repeat (3) @(negedge clk);
    check("R1", pos, '0);
    check("R1", init_val, '0);
    check("R1", max_val, '1);
    check("R1", {31'd0, phase_err}, 32'd0);
    rst_n = 1'b1;
    enable = 1'b1;
    cyc("R2");
    // R8: down from zero wraps to all ones
    gstep(3); cyc("R8");
    check("R8", pos, 32'hFFFF_FFFF);
    gstep(1); cyc("R2");
    check("R2", pos, 32'd0);
    gstep(1); cyc("R2"); gstep(1); cyc("R2");
    check("R2", pos, 32'd2);
    // R3: illegal jump
    gstep(2); cyc("R3");
    check("R3", {31'd0, phase_err}, 32'd1);
    check("R3", pos, 32'd2);
    cyc("R3");
    check("R3", {31'd0, phase_err}, 32'd0);
    // R10
    wr_data = 32'd5; wr_max = 1; cyc("R10");
    wr_data = 32'd4; wr_init = 1; cyc("R10");
    check("R10", init_val, 32'd4);
    sw_init = 1; cyc("R10");
    check("R10", pos, 32'd4);
    wr_data = 32'd1; wr_pos = 1; sw_init = 1; gstep(1); cyc("R10");
    check("R10", pos, 32'd1);
    // R5: up mode, falling edge ignored
    mode = 2'd2; a_in = 0; b_in = 0; cyc("R5");
    a_in = 1; cyc("R5"); check("R5", pos, 32'd2);
    a_in = 0; cyc("R5"); check("R5", pos, 32'd2);
    // R6: swap, rising B pin counts
    swap = 1; b_in = 1; cyc("R6"); check("R6", pos, 32'd3);
    swap = 0; b_in = 0; cyc("R6");
    // R9
    enable = 0; a_in = 1; cyc("R9"); check("R9", pos, 32'd3);
    enable = 1;
    for (int seg = 0; seg < 16; seg++) begin
      string tag;
      mode = seg[1:0];
      swap = $urandom_range(0, 1); inv_a = $urandom_range(0, 1); inv_b = $urandom_range(0, 1);
      inv_idx = $urandom_range(0, 1); inv_strb = $urandom_range(0, 1);
      tag = (mode == 0) ? "R2" : (mode == 1) ? "R4" : "R5";
      for (int i = 0; i < 400; i++) begin
        int r;
        r = $urandom_range(0, 99);
        if (mode == 0) begin
          if (r < 40) gstep(1); else if (r < 75) gstep(3); else if (r < 79) gstep(2);
        end else begin
          a_in = $urandom_range(0, 1); b_in = $urandom_range(0, 1);
        end
        idx_in = $urandom_range(0, 1); strb_in = $urandom_range(0, 1);
        enable = ($urandom_range(0, 19) != 0);
        r = $urandom_range(0, 199);
        wr_data = $urandom_range(0, 7);
        if (r == 0) wr_pos = 1; else if (r == 1) sw_init = 1;
        else if (r == 2) wr_init = 1; else if (r == 3) wr_max = 1;
        cyc(tag);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule